// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the address for each beat of a fixed four-beat memory burst. When a new address is loaded, it records the full address and resets a beat counter. From then on, each cycle with advance enabled moves the counter on by one beat. The low address bits are formed from the loaded base bits and the beat count. A static order input picks between two orders. In sequential order the low bits count up and wrap. In interleaved order the low bits are the base bits XOR the beat count. The upper address bits come from the loaded address and do not change during a burst.

A memory controller places the block between its address capture and the array decoder. It pulses the load strobe with each new access and holds the suspend input high for any cycle in which the burst must wait. The output is registered state seen through a small mapping, so the address for a beat is valid in the cycle after the edge that set it up.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no other activity, `addr_o` is all zeros.
- R2: In the cycle after a clock edge with `load_i` high, `addr_o` equals the `addr_i` value sampled at that edge. This is beat 0 of the burst.
- R3: `load_i` takes priority over advance. A load with `suspend_i` low still gives beat 0 and does not give beat 1.
- R4: At an edge with `load_i` low and `suspend_i` high, the beat count holds and `addr_o` does not change.
- R5: With `order_i` = 0 (sequential), beat k has low bits (base + k) mod 4.
- R6: With `order_i` = 1 (interleaved), beat k has low bits base XOR k.
- R7: Four advances after a load bring the low bits back to the base value. After that the sequence repeats.
- R8: The bits of `addr_o` above the two low bits equal the bits of the loaded address. They do not change until the next load.
- R9: A load in the middle of a burst drops the current burst and starts again at beat 0 of the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture `addr_i` as the new burst base |
| addr_i | input | ADDR_W | Address to load |
| suspend_i | input | 1 | 1 holds the current beat, 0 advances it |
| order_i | input | 1 | Burst order: 0 sequential, 1 interleaved; static |
| addr_o | output | ADDR_W | Address of the current beat |

## Verification
The assertions assume that `order_i` changes only in a cycle where `load_i` is also high. The output mapping is combinational from `order_i`, so any other change would look like a spurious address step. The bench follows this rule: it sets the order before reset is released, and it changes the order only together with a load. Inside that rule the bench sweeps every base value in both orders. It mixes suspend cycles and advances, continues past the wrap point, and reloads in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_o <= '0;
    else if (load_i) base_o <= addr_i;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               suspend_i,
  output logic [BURST_W-1:0] beat_o
);
  // load wins over advance; width gives wraparound
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         beat_o <= '0;
    else if (load_i)     beat_o <= '0;
    else if (!suspend_i) beat_o <= beat_o + 1'b1;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  burst_order_e       order_i,
  input  logic [BURST_W-1:0] base_lo_i,
  input  logic [BURST_W-1:0] beat_i,
  output logic [BURST_W-1:0] lo_o
);
  logic [BURST_W-1:0] seq_lo;
  logic [BURST_W-1:0] intlv_lo;

  assign seq_lo = base_lo_i + beat_i;

  for (genvar i = 0; i < BURST_W; i++) begin : g_xor
    assign intlv_lo[i] = base_lo_i[i] ^ beat_i[i];
  end

  always_comb begin
    unique case (order_i)
      ORD_INTLV: lo_o = intlv_lo;
      default:   lo_o = seq_lo;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              suspend_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] lo;
  burst_order_e       order;

  assign order = burst_order_e'(order_i);

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .addr_i (addr_i),
    .base_o (base_q)
  );

  burst_beat_cnt #(.BURST_W(BURST_W)) u_beat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .suspend_i (suspend_i),
    .beat_o    (beat_q)
  );

  burst_order_map #(.BURST_W(BURST_W)) u_map (
    .order_i   (order),
    .base_lo_i (base_q[BURST_W-1:0]),
    .beat_i    (beat_q),
    .lo_o      (lo)
  );

  if (UP_W > 0) begin : g_up
    assign addr_o = {base_q[ADDR_W-1:BURST_W], lo};
  end else begin : g_noup
    assign addr_o = lo;
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              suspend_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic [BURST_W-1:0] sh_base;
  logic [BURST_W-1:0] sh_cnt;
  logic [BURST_W-1:0] sh_seq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_base <= '0;
      sh_cnt  <= '0;
    end else if (load_i) begin
      sh_base <= addr_i[BURST_W-1:0];
      sh_cnt  <= '0;
    end else if (!suspend_i) begin
      sh_cnt  <= sh_cnt + 1'b1;
    end
  end

  assign sh_seq = sh_base + sh_cnt;

  always_comb begin
    if (!rst_ni) AST_RESET_ZERO: assert (addr_o == '0); // R1
  end

  AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(addr_i)); // R2

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !suspend_i) |=> addr_o[BURST_W-1:0] == $past(addr_i[BURST_W-1:0])); // R3

  AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && suspend_i && $stable(order_i)) |=> $stable(addr_o)); // R4

  AST_SEQ_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !order_i |-> addr_o[BURST_W-1:0] == sh_seq); // R5

  AST_INTLV_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    order_i |-> addr_o[BURST_W-1:0] == (sh_base ^ sh_cnt)); // R6

  AST_UPPER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> addr_o[ADDR_W-1:BURST_W] == $past(addr_o[ADDR_W-1:BURST_W])); // R8
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .addr_i    (addr_i),
  .suspend_i (suspend_i),
  .order_i   (order_i),
  .addr_o    (addr_o)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int ADDR_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              suspend_i = 1'b1;
  logic              order_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [ADDR_W-1:0] exp_base;
  logic [1:0]        exp_k;

  always #4 clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_W(2)) u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .addr_i    (addr_i),
    .suspend_i (suspend_i),
    .order_i   (order_i),
    .addr_o    (addr_o)
  );

  function automatic logic [ADDR_W-1:0] model(input logic [ADDR_W-1:0] b,
                                              input logic [1:0] k,
                                              input logic ord);
    logic [1:0] lo;
    lo = ord ? (b[1:0] ^ k) : 2'((b[1:0] + k) % 4);
    return {b[ADDR_W-1:2], lo};
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    n_chk++;
    if (addr_o !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_o=%h expected %h", req, addr_o, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_load(input logic [ADDR_W-1:0] a, input logic susp, input string req);
    load_i = 1'b1; addr_i = a; suspend_i = susp;
    tick();
    load_i = 1'b0; suspend_i = 1'b1;
    exp_base = a; exp_k = 2'd0;
    check(req, model(exp_base, exp_k, order_i));
  endtask

  task automatic do_step(input logic susp, input string req);
    suspend_i = susp;
    tick();
    suspend_i = 1'b1;
    if (!susp) exp_k = exp_k + 2'd1;
    check(req, model(exp_base, exp_k, order_i));
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    check("R1 in reset", '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    check("R1 after reset", '0);

    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 4; b++) begin
        order_i = m[0];
        // R3: load with advance requested still yields beat 0
        do_load({14'h1A5 + 14'(b * 37 + m * 5), 2'(b)}, 1'b0, "R2/R3 load");
        do_step(1'b0, m ? "R6 beat1" : "R5 beat1");
        do_step(1'b1, "R4 suspend");
        do_step(1'b0, m ? "R6 beat2" : "R5 beat2");
        do_step(1'b1, "R4 suspend");
        do_step(1'b1, "R4 suspend");
        do_step(1'b0, m ? "R6 beat3" : "R5 beat3");
        do_step(1'b0, "R7 wrap");
        check("R7 back at base", exp_base);
        do_step(1'b0, "R7 repeat");
        // R8: upper bits from loaded address
        n_chk++;
        if (addr_o[ADDR_W-1:2] !== exp_base[ADDR_W-1:2]) begin
          n_fail++;
          $display("FAIL R8: upper=%h expected %h", addr_o[ADDR_W-1:2], exp_base[ADDR_W-1:2]);
        end
      end
    end

    // R9: reload in the middle of a burst, both orders
    for (int m = 0; m < 2; m++) begin
      order_i = m[0];
      do_load(16'h3C01, 1'b1, "R2 load held");
      do_step(1'b0, "R9 pre");
      do_step(1'b0, "R9 pre");
      do_load(16'hC3F2, 1'b0, "R9 reload");
      do_step(1'b0, "R9 after reload");
      do_step(1'b1, "R4 after reload");
      do_step(1'b0, "R9 after reload");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule